// File: doc/BRIEF.md
# Deep Sleep Wake Controller

This block sequences a processor's exit from its deepest low-power state. Software raises a sleep request while the core is running. The controller then gates the core clock until a wake source appears. Two kinds of wake are handled. A qualified interrupt leads into interrupt handling. Any of four reset sources leads into reset handling: the external reset pin, a power-on reset, a supply-monitor reset, or a watchdog underflow.

The controller reports which handling path to start with a one-cycle pulse. Reset sources always win over an interrupt. An interrupt only wakes the core when its priority is strictly above the core's current mask level.

The external pin needs a minimum low time. A shorter glitch is discarded. Watchdog wakes can be suppressed by configuration when the watchdog is set to pause while asleep.

Top module: `dsleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the running state and `clk_stop_en`, `irq_start` and `rst_start` are all 0.
- R2: A `sleep_req` sampled high while running, with no reset source active, sets `clk_stop_en` to 1 from the next cycle. `clk_stop_en` is 1 only in deep sleep.
- R3: In deep sleep, `irq_req` with `irq_prio` > `cpu_mask` (unsigned 4-bit compare) clears `clk_stop_en` in the next cycle. One cycle later `irq_start` is 1 for exactly one cycle, and `rst_start` stays 0.
- R4: In deep sleep, an interrupt with `irq_prio` <= `cpu_mask` (including equal) leaves `clk_stop_en` at 1 and produces no pulse.
- R5: `irq_req` while running has no effect: `clk_stop_en` stays 0 and no `irq_start` follows.
- R6: `rst_pin_n` held low for at least 16 consecutive clock edges and then released gives a reset wake, with `rst_start` pulsing one cycle after the release is sampled. A low pulse of 15 edges or fewer is ignored.
- R7: While `por_rst` or `lvd_rst` is high, `clk_stop_en`, `irq_start` and `rst_start` are 0. At the first edge after release, `rst_start` pulses for one cycle.
- R8: The watchdog is paused in deep sleep when (`wdt_autostart`=0 and `wdt_opt_stop`=1) or (`wdt_autostart`=1 and `wdt_reg_stop`=1). In that case `wdt_underflow` in deep sleep is ignored. Otherwise an underflow wakes the block with a reset wake (`rst_start` timing as in R3).
- R9: A reset source sampled in the same cycle as a qualifying interrupt gives `rst_start` and never `irq_start`.
- R10: `irq_start` and `rst_start` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sleep_req | input | 1 | Request to enter deep sleep |
| irq_req | input | 1 | Pending interrupt request |
| irq_prio | input | 4 | Priority level of the pending interrupt |
| cpu_mask | input | 4 | Core's current interrupt priority mask level |
| rst_pin_n | input | 1 | External reset pin, active low |
| por_rst | input | 1 | Power-on reset, active high |
| lvd_rst | input | 1 | Supply-voltage monitor reset, active high |
| wdt_underflow | input | 1 | Watchdog underflow event |
| wdt_autostart | input | 1 | Watchdog auto-start configuration bit |
| wdt_opt_stop | input | 1 | Option-setting pause-in-sleep bit (used when auto-start is 0) |
| wdt_reg_stop | input | 1 | Register pause-in-sleep bit (used when auto-start is 1) |
| clk_stop_en | output | 1 | Core clock stop enable, high in deep sleep |
| irq_start | output | 1 | One-cycle pulse: start interrupt handling |
| rst_start | output | 1 | One-cycle pulse: start reset handling |

## Verification
A vector table puts the block to sleep and then presents one wake candidate per entry. The candidates are interrupts with priority above, equal to, and below the mask; each reset source; and all four watchdog configuration combinations. Together these separate a strict priority compare from an inclusive one and a paused watchdog from a running one. Mixed entries pair an interrupt with a reset source, showing that the reset path wins. Directed tests drive reset-pin pulses of 15 and 16 edges to locate the filter threshold. They also hold a power-on reset over several cycles, to show that the pulse waits for release, and raise an interrupt while running, to show that only sleep is affected.

// File: rtl/dsw_pkg.sv
// Package: shared state and wake-cause types for the deep sleep wake controller.
// Assumes: single clock domain; all users import this package.
package dsw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } dsw_state_e;

    typedef enum logic {
        WK_IRQ = 1'b0,
        WK_RST = 1'b1
    } dsw_cause_e;
endpackage

// File: rtl/dsw_pin_filter.sv
// Module: dsw_pin_filter
// Measures how long the external reset pin has been low with a saturating
// counter. It reports a held reset once the minimum low time is reached, and a
// release event on the first high sample after that.
// Assumes: pin already synchronised to clk; synchronous active-low rst_n.
module dsw_pin_filter #(
    parameter int MIN_LOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_hold,
    output logic pin_release
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_cnt;
    logic             qualified;

    // Count consecutive low samples, saturating at the minimum low time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (pin_n)
            low_cnt <= '0;
        else if (low_cnt != CNT_MAX)
            low_cnt <= low_cnt + 1'b1;
    end

    // Decode the held and released conditions from the counter.
    assign qualified   = (low_cnt == CNT_MAX);
    assign pin_hold    = !pin_n && qualified;
    assign pin_release = pin_n && qualified;

    assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_release |=> (low_cnt == '0));

    assert_short_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_n && $past(pin_n)) |-> !pin_release);
endmodule

// File: rtl/dsw_wake_qual.sv
// Module: dsw_wake_qual
// Combinational qualification of the wake sources. It gates interrupts by a
// strict priority compare against the mask, and applies the watchdog
// pause-in-sleep rule. It folds all reset sources into a held level and a
// one-cycle trigger.
// Assumes: inputs are synchronous to the controller clock.
module dsw_wake_qual #(
    parameter int PRIO_W = 4
) (
    input  logic              in_sleep,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cpu_mask,
    input  logic              por_rst,
    input  logic              lvd_rst,
    input  logic              pin_hold,
    input  logic              pin_release,
    input  logic              wdt_underflow,
    input  logic              wdt_autostart,
    input  logic              wdt_opt_stop,
    input  logic              wdt_reg_stop,
    output logic              irq_wake,
    output logic              rst_hold,
    output logic              rst_trig
);
    logic wdt_paused;
    logic wdt_reset;

    // Choose which pause bit applies, from the auto-start mode.
    always_comb wdt_paused = wdt_autostart ? wdt_reg_stop : wdt_opt_stop;

    // A paused watchdog cannot underflow while the core sleeps.
    always_comb wdt_reset = wdt_underflow && !(in_sleep && wdt_paused);

    // Only an interrupt strictly above the mask can end deep sleep.
    always_comb irq_wake = in_sleep && irq_req && (irq_prio > cpu_mask);

    // Level-type reset sources, and every source that forces a reset wake.
    always_comb rst_hold = por_rst || lvd_rst || pin_hold;
    always_comb rst_trig = rst_hold || pin_release || wdt_reset;
endmodule

// File: rtl/dsw_fsm.sv
// Module: dsw_fsm
// Three-state sequencer (run, deep sleep, wake). A reset trigger has top
// priority and parks the machine in wake until every held reset is released.
// Leaving wake emits a one-cycle start pulse for the recorded cause.
// Assumes: wake qualifiers come from dsw_wake_qual in the same cycle.
module dsw_fsm
    import dsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_wake,
    input  logic       rst_trig,
    output dsw_state_e state,
    output logic       clk_stop_en,
    output logic       irq_start,
    output logic       rst_start
);
    dsw_cause_e cause;
    logic       leaving;

    // Next-state and cause register; reset sources override everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cause <= WK_IRQ;
        end else if (rst_trig) begin
            state <= ST_WAKE;
            cause <= WK_RST;
        end else begin
            unique case (state)
                ST_RUN:   if (sleep_req) state <= ST_SLEEP;
                ST_SLEEP: if (irq_wake) begin
                              state <= ST_WAKE;
                              cause <= WK_IRQ;
                          end
                ST_WAKE:  state <= ST_RUN;
                default:  state <= ST_RUN;
            endcase
        end
    end

    // Wake is left on any cycle without a reset trigger.
    assign leaving = (state == ST_WAKE) && !rst_trig;

    // Register the start pulses so they appear in the first cycle after wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_start <= 1'b0;
            rst_start <= 1'b0;
        end else begin
            irq_start <= leaving && (cause == WK_IRQ);
            rst_start <= leaving && (cause == WK_RST);
        end
    end

    // Core clock is gated only while asleep.
    assign clk_stop_en = (state == ST_SLEEP);

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_en) |-> $past(sleep_req));

    assert_irq_from_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> ($past(state) == ST_WAKE));

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_trig |=> (state == ST_WAKE && cause == WK_RST && !irq_start));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_start || rst_start) |=> !(irq_start || rst_start));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_start && rst_start));
endmodule

// File: rtl/dsleep_wake_ctrl.sv
// Module: dsleep_wake_ctrl (top)
// Deep sleep wake controller: pin filter, wake qualification and sequencer.
// Assumes: every input is synchronous to clk; block reset is synchronous,
// active low.
module dsleep_wake_ctrl
    import dsw_pkg::*;
#(
    parameter int PRIO_W  = 4,
    parameter int MIN_LOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cpu_mask,
    input  logic              rst_pin_n,
    input  logic              por_rst,
    input  logic              lvd_rst,
    input  logic              wdt_underflow,
    input  logic              wdt_autostart,
    input  logic              wdt_opt_stop,
    input  logic              wdt_reg_stop,
    output logic              clk_stop_en,
    output logic              irq_start,
    output logic              rst_start
);
    dsw_state_e state;
    logic       pin_hold;
    logic       pin_release;
    logic       irq_wake;
    logic       rst_hold;
    logic       rst_trig;
    logic       in_sleep;

    assign in_sleep = (state == ST_SLEEP);

    dsw_pin_filter #(.MIN_LOW(MIN_LOW)) u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (rst_pin_n),
        .pin_hold    (pin_hold),
        .pin_release (pin_release)
    );

    dsw_wake_qual #(.PRIO_W(PRIO_W)) u_qual (
        .in_sleep      (in_sleep),
        .irq_req       (irq_req),
        .irq_prio      (irq_prio),
        .cpu_mask      (cpu_mask),
        .por_rst       (por_rst),
        .lvd_rst       (lvd_rst),
        .pin_hold      (pin_hold),
        .pin_release   (pin_release),
        .wdt_underflow (wdt_underflow),
        .wdt_autostart (wdt_autostart),
        .wdt_opt_stop  (wdt_opt_stop),
        .wdt_reg_stop  (wdt_reg_stop),
        .irq_wake      (irq_wake),
        .rst_hold      (rst_hold),
        .rst_trig      (rst_trig)
    );

    dsw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .irq_wake    (irq_wake),
        .rst_trig    (rst_trig),
        .state       (state),
        .clk_stop_en (clk_stop_en),
        .irq_start   (irq_start),
        .rst_start   (rst_start)
    );

    assert_masked_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_en && irq_req && (irq_prio <= cpu_mask) && !por_rst && !lvd_rst
         && !pin_release && rst_pin_n && !wdt_underflow && !sleep_req)
        |=> clk_stop_en);

    assert_held_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (por_rst || lvd_rst) |=> (!clk_stop_en && !irq_start && !rst_start));

    assert_wdt_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_en && wdt_underflow && !irq_req && !rst_hold && !pin_release
         && (wdt_autostart ? wdt_reg_stop : wdt_opt_stop)) |=> clk_stop_en);
endmodule

// File: tb/dsleep_wake_ctrl_bench.sv
// Bench for dsleep_wake_ctrl: a vector table of wake candidates applied in
// deep sleep, then directed tests for reset, pin filter, held reset, run mode.
module dsleep_wake_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 13;

    // {irq, prio[4], mask[4], por, lvd, wdt, auto, opt, reg, exp_irq, exp_rst}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 4'd5,  4'd3,  6'b000000, 2'b10},  // R3 above mask
        {1'b1, 4'd3,  4'd3,  6'b000000, 2'b00},  // R4 equal
        {1'b1, 4'd2,  4'd7,  6'b000000, 2'b00},  // R4 below
        {1'b1, 4'd15, 4'd14, 6'b000000, 2'b10},  // R3 top prio
        {1'b0, 4'd5,  4'd0,  6'b000000, 2'b00},  // no request
        {1'b0, 4'd0,  4'd0,  6'b100000, 2'b01},  // R7 por
        {1'b0, 4'd0,  4'd0,  6'b010000, 2'b01},  // R7 lvd
        {1'b0, 4'd0,  4'd0,  6'b001001, 2'b01},  // R8 auto0 opt0 reg1 runs
        {1'b0, 4'd0,  4'd0,  6'b001010, 2'b00},  // R8 auto0 opt1 paused
        {1'b0, 4'd0,  4'd0,  6'b001101, 2'b00},  // R8 auto1 reg1 paused
        {1'b0, 4'd0,  4'd0,  6'b001110, 2'b01},  // R8 auto1 opt1 reg0 runs
        {1'b1, 4'd9,  4'd1,  6'b100000, 2'b01},  // R9 irq + por
        {1'b1, 4'd1,  4'd0,  6'b001100, 2'b01}   // R9 irq + wdt
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq_req = 1'b0;
    logic [3:0] irq_prio = '0;
    logic [3:0] cpu_mask = '0;
    logic       rst_pin_n = 1'b1;
    logic       por_rst = 1'b0;
    logic       lvd_rst = 1'b0;
    logic       wdt_underflow = 1'b0;
    logic       wdt_autostart = 1'b0;
    logic       wdt_opt_stop = 1'b0;
    logic       wdt_reg_stop = 1'b0;
    logic       clk_stop_en;
    logic       irq_start;
    logic       rst_start;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsleep_wake_ctrl u_dsleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_req(irq_req),
        .irq_prio(irq_prio), .cpu_mask(cpu_mask), .rst_pin_n(rst_pin_n),
        .por_rst(por_rst), .lvd_rst(lvd_rst), .wdt_underflow(wdt_underflow),
        .wdt_autostart(wdt_autostart), .wdt_opt_stop(wdt_opt_stop),
        .wdt_reg_stop(wdt_reg_stop), .clk_stop_en(clk_stop_en),
        .irq_start(irq_start), .rst_start(rst_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        sleep_req = 0; irq_req = 0; irq_prio = 0; cpu_mask = 0;
        por_rst = 0; lvd_rst = 0; wdt_underflow = 0;
        wdt_autostart = 0; wdt_opt_stop = 0; wdt_reg_stop = 0;
        rst_pin_n = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_inputs();
        repeat (3) cyc();
        rst_n = 1;
    endtask

    task automatic go_sleep();
        sleep_req = 1;
        cyc();
        sleep_req = 0;
        chk("R2 clk_stop_en after sleep_req", int'(clk_stop_en), 1);
    endtask

    initial begin
        do_reset();
        chk("R1 clk_stop_en reset", int'(clk_stop_en), 0);
        chk("R1 irq_start reset", int'(irq_start), 0);
        chk("R1 rst_start reset", int'(rst_start), 0);
        cyc();
        chk("R2 stays running without request", int'(clk_stop_en), 0);

        // Vector table: one wake candidate applied for one cycle in deep sleep.
        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] v;
            logic        wake;
            v = VEC[i];
            wake = v[1] | v[0];
            do_reset();
            go_sleep();
            irq_req = v[16]; irq_prio = v[15:12]; cpu_mask = v[11:8];
            por_rst = v[7]; lvd_rst = v[6]; wdt_underflow = v[5];
            wdt_autostart = v[4]; wdt_opt_stop = v[3]; wdt_reg_stop = v[2];
            cyc();
            clear_inputs();
            chk($sformatf("R3/R4/R8 vec%0d clk_stop_en", i), int'(clk_stop_en), int'(!wake));
            cyc();
            chk($sformatf("R3/R9 vec%0d irq_start", i), int'(irq_start), int'(v[1]));
            chk($sformatf("R7/R8/R9 vec%0d rst_start", i), int'(rst_start), int'(v[0]));
            cyc();
            chk($sformatf("R10 vec%0d pulse cleared", i), int'(irq_start | rst_start), 0);
            chk($sformatf("R2 vec%0d clk_stop_en after", i), int'(clk_stop_en), int'(!wake));
        end

        // R5: interrupt while running does nothing.
        do_reset();
        irq_req = 1; irq_prio = 4'd9; cpu_mask = 4'd0;
        cyc();
        clear_inputs();
        chk("R5 clk_stop_en in run", int'(clk_stop_en), 0);
        cyc();
        chk("R5 no irq_start in run", int'(irq_start), 0);

        // R6: 15-edge low pulse ignored.
        do_reset();
        go_sleep();
        rst_pin_n = 0;
        repeat (15) cyc();
        rst_pin_n = 1;
        repeat (3) begin
            cyc();
            chk("R6 short pin pulse keeps sleep", int'(clk_stop_en), 1);
            chk("R6 short pin pulse no rst_start", int'(rst_start), 0);
        end

        // R6: 16-edge low pulse accepted.
        do_reset();
        go_sleep();
        rst_pin_n = 0;
        repeat (16) cyc();
        chk("R6 asleep while counting", int'(clk_stop_en), 1);
        rst_pin_n = 1;
        cyc();
        chk("R6 release leaves sleep", int'(clk_stop_en), 0);
        chk("R6 no pulse at release edge", int'(rst_start), 0);
        cyc();
        chk("R6 rst_start after release", int'(rst_start), 1);
        cyc();
        chk("R10 R6 pulse one cycle", int'(rst_start), 0);

        // R7: power-on reset held for several cycles.
        do_reset();
        go_sleep();
        por_rst = 1;
        repeat (5) begin
            cyc();
            chk("R7 held clk_stop_en", int'(clk_stop_en), 0);
            chk("R7 held no rst_start", int'(rst_start), 0);
        end
        por_rst = 0;
        cyc();
        chk("R7 rst_start after release", int'(rst_start), 1);
        chk("R7 irq_start stays low", int'(irq_start), 0);
        cyc();
        chk("R10 R7 pulse one cycle", int'(rst_start), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule